// File: doc/BRIEF.md
# Latched Vectored Interrupt Controller

This block collects four interrupt sources for a small CPU core: an asynchronous external interrupt pin, a time-out pulse from each of two timers, and a transfer-complete pulse from a serial shifter. Each event is captured in its own pending flag, which stays set until software clears it. The external pin first crosses into the core clock through a two-flop synchronizer. An edge detector, whose direction software selects, then sets its flag.

Every flag is gated by its own mask or enable bit. The gated requests are combined into one registered interrupt request. They also drive a registered 16-bit vector address that points at the low byte of the vector pair of the highest-priority unmasked source. Software reaches the flags, the masks and the edge select through a byte-wide register port. The control register sits at byte address 0x0E. A mode register at 0x10 holds the serial flag and the serial enable.

Top module: `vec_irq_top`

## Requirements
- R1: After reset, the control register (address 0x0E) reads 0x01 and the mode register (address 0x10) reads 0x00. The request output is low and the vector output is 0xFFFE.
- R2: A one-cycle Timer A pulse sets control bit 4 and a one-cycle Timer B pulse sets control bit 5. A one-cycle serial transfer-complete pulse sets mode bit 7. Each flag reads as set in the cycle after the clock edge at which its pulse was high.
- R3: Control bit 6 selects the external edge: 0 for falling, 1 for rising. A selected edge on the external pin sets control bit 3. The pin passes through two synchronizer flops and an edge register, so the flag reads as set after the third rising clock edge following the pin change, and not after the second.
- R4: A flag bit (control bits 3, 4 and 5, mode bit 7) clears only when software writes 0 to that bit at its register address. Writing 1 to a flag leaves it unchanged. If a source event and a clearing write occur in the same cycle, the flag stays set.
- R5: A gate bit of 1 passes its source and a gate bit of 0 blocks it. Control bit 0 gates the external source, bit 1 gates Timer A, and bit 2 gates Timer B. Mode bit 0 enables the serial source. A blocked flag stays pending but does not raise the request.
- R6: The request output is a register. It goes high one clock edge after any flag and its gate bit are both set, and goes low one edge after no such pair remains.
- R7: The vector output is registered with the same timing as the request. Its value follows a fixed priority: external 0xFFFA, then Timer A 0xFFF8, then Timer B 0xFFF6, then serial 0xFFF4. It is 0xFFFE while no gated request is pending.
- R8: Control bit 7 and mode bits 6 to 1 always read 0. Writes to any other address change no register. Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | Asynchronous external interrupt pin |
| tmrAPulse | input | 1 | One-cycle Timer A time-out strobe |
| tmrBPulse | input | 1 | One-cycle Timer B time-out strobe |
| serDonePulse | input | 1 | One-cycle serial transfer-complete strobe |
| busAddr | input | 8 | Register byte address for reads and writes |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data of the addressed register |
| irqOut | output | 1 | Registered interrupt request to the CPU |
| vecAddr | output | 16 | Registered low-byte address of the selected vector pair |

## Verification
Some properties are checked on every cycle. A Timer A strobe must always leave its flag set. A set flag must survive any cycle without a clearing write. The request must equal, one edge later, the OR of the gated flags. The vector output must be the idle value exactly when the request is low and a legal source vector otherwise. Other behaviour is shown only by the bench scenarios: the three-edge latency of the synchronized external edge in both polarities, the fixed priority when several sources are pending together, an event winning over a clear in the same cycle, and the reserved bits and foreign addresses having no effect. A long random run adds coverage by comparing every output against a cycle model.

// File: rtl/vec_irq_pkg.sv
`timescale 1ns/1ps
package vec_irq_pkg;
  // Source index order is also the priority order (index 0 wins)
  localparam int NUM_SRC = 4;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMRA = 1;
  localparam int SRC_TMRB = 2;
  localparam int SRC_SER = 3;

  // Control register bit positions
  localparam int CTL_POL = 6;
  localparam int CTL_FLAG_LO = 3;   // flags occupy 3..5 for sources 0..2
  localparam int CTL_MASK_LO = 0;   // masks occupy 0..2 for sources 0..2
  // Mode register bit positions
  localparam int MODE_FLAG = 7;
  localparam int MODE_EN = 0;

  localparam logic [7:0] CTL_RESET = 8'h01;
  localparam logic [15:0] IDLE_VEC = 16'hFFFE;
  localparam logic [15:0] TOP_VEC = 16'hFFFA;

  // Vector pairs step down by two bytes per priority level
  function automatic logic [15:0] srcVector(input int idx);
    return TOP_VEC - 16'(2 * idx);
  endfunction

  typedef struct packed {
    logic wrCtl;
    logic wrMode;
    logic rdCtl;
    logic rdMode;
    logic extEdge;
    logic setTmrA;
    logic setTmrB;
    logic setSer;
  } strobe_t;
endpackage

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic              edgeRise,
  input  logic              tmrAPulse,
  input  logic              tmrBPulse,
  input  logic              serDonePulse,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  output strobe_t           stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   selCtl;
  logic                   selMode;

  // Synchronizer chain for the asynchronous pin
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ[g] <= 1'b0;
        end else begin
          if (g == 0) syncQ[g] <= extPin;
          else        syncQ[g] <= syncQ[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST];
  end

  assign selCtl  = (busAddr == CTL_ADDR);
  assign selMode = (busAddr == MODE_ADDR);

  always_comb begin
    stb.wrCtl   = wrEn & selCtl;
    stb.wrMode  = wrEn & selMode;
    stb.rdCtl   = selCtl;
    stb.rdMode  = selMode;
    stb.extEdge = edgeRise ? (syncQ[LAST] & ~prevQ) : (~syncQ[LAST] & prevQ);
    stb.setTmrA = tmrAPulse;
    stb.setTmrB = tmrBPulse;
    stb.setSer  = serDonePulse;
  end
endmodule

// File: rtl/vec_irq_dp.sv
`timescale 1ns/1ps
module vec_irq_dp
  import vec_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        edgeRise,
  output logic        irqOut,
  output logic [15:0] vecAddr,
  output logic [7:0]  ctlView,
  output logic [7:0]  modeView
);
  localparam int CTL_SRC = NUM_SRC - 1;  // sources handled in the control register

  logic                 polQ;
  logic [CTL_SRC-1:0]   maskQ;
  logic                 serEnQ;
  logic [NUM_SRC-1:0]   flagQ;
  logic [NUM_SRC-1:0]   setVec;
  logic [NUM_SRC-1:0]   clrVec;
  logic [NUM_SRC-1:0]   gateVec;
  logic [NUM_SRC-1:0]   pending;
  logic [15:0]          nextVec;

  assign setVec  = {stb.setSer, stb.setTmrB, stb.setTmrA, stb.extEdge};
  assign gateVec = {serEnQ, maskQ};
  assign pending = flagQ & gateVec;

  // Clear strobes: writing 0 to a flag bit clears it
  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_flag
      if (i < CTL_SRC) begin : g_ctl
        assign clrVec[i] = stb.wrCtl & ~wrData[CTL_FLAG_LO + i];
      end else begin : g_mode
        assign clrVec[i] = stb.wrMode & ~wrData[MODE_FLAG];
      end
      // An event in the same cycle as a clear keeps the flag set
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           flagQ[i] <= 1'b0;
        else if (setVec[i])  flagQ[i] <= 1'b1;
        else if (clrVec[i])  flagQ[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ  <= CTL_RESET[CTL_POL];
      maskQ <= CTL_RESET[CTL_MASK_LO +: CTL_SRC];
    end else if (stb.wrCtl) begin
      polQ  <= wrData[CTL_POL];
      maskQ <= wrData[CTL_MASK_LO +: CTL_SRC];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            serEnQ <= 1'b0;
    else if (stb.wrMode)  serEnQ <= wrData[MODE_EN];
  end

  // Fixed priority: the lowest index pending source wins
  always_comb begin
    nextVec = IDLE_VEC;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pending[k]) nextVec = srcVector(k);
    end
  end

  // Output synchronization stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      vecAddr <= IDLE_VEC;
    end else begin
      irqOut  <= |pending;
      vecAddr <= nextVec;
    end
  end

  assign ctlView  = {1'b0, polQ, flagQ[CTL_SRC-1:0], maskQ};
  assign modeView = {flagQ[SRC_SER], 6'b000000, serEnQ};
  assign edgeRise = polQ;
  assign rdData   = stb.rdCtl ? ctlView : (stb.rdMode ? modeView : 8'h00);
endmodule

// File: rtl/vec_irq_top.sv
`timescale 1ns/1ps
module vec_irq_top
  import vec_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic              tmrAPulse,
  input  logic              tmrBPulse,
  input  logic              serDonePulse,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irqOut,
  output logic [15:0]       vecAddr
);
  strobe_t    stb;
  logic       edgeRise;
  logic [7:0] ctlView;
  logic [7:0] modeView;

  vec_irq_ctrl #(
    .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .MODE_ADDR(MODE_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .edgeRise(edgeRise),
    .tmrAPulse(tmrAPulse), .tmrBPulse(tmrBPulse), .serDonePulse(serDonePulse),
    .busAddr(busAddr), .wrEn(wrEn), .stb(stb)
  );

  vec_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdData(rdData),
    .edgeRise(edgeRise), .irqOut(irqOut), .vecAddr(vecAddr),
    .ctlView(ctlView), .modeView(modeView)
  );
endmodule

// File: rtl/vec_irq_chk.sv
`timescale 1ns/1ps
module vec_irq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tmrAPulse,
  input logic        flagA,
  input logic        clrA,
  input logic [3:0]  gatedVec,
  input logic        irqOut,
  input logic [15:0] vecAddr
);
  p_tmra_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    tmrAPulse |=> flagA);

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flagA && !clrA) |=> flagA);

  p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|gatedVec)));

  p_idle_vec_r7: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (vecAddr == 16'hFFFE));

  p_vec_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (vecAddr inside {16'hFFFA, 16'hFFF8, 16'hFFF6, 16'hFFF4}));
endmodule

bind vec_irq_top vec_irq_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .tmrAPulse(tmrAPulse),
  .flagA(ctlView[4]),
  .clrA(wrEn && (busAddr == CTL_ADDR) && !wrData[4]),
  .gatedVec({modeView[7] & modeView[0], ctlView[5] & ctlView[2],
             ctlView[4] & ctlView[1], ctlView[3] & ctlView[0]}),
  .irqOut(irqOut),
  .vecAddr(vecAddr)
);

// File: tb/vec_irq_top_tb.sv
`timescale 1ns/1ps
module vec_irq_top_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, extPin, tmrAPulse, tmrBPulse, serDonePulse, wrEn;
  logic [7:0] busAddr, wrData, rdData;
  logic irqOut;
  logic [15:0] vecAddr;

  int errs = 0;
  int checks = 0;

  vec_irq_top u_dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .tmrAPulse(tmrAPulse),
    .tmrBPulse(tmrBPulse), .serDonePulse(serDonePulse), .busAddr(busAddr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut),
    .vecAddr(vecAddr)
  );

  // ---------------- cycle model built from the requirements ----------------
  logic [7:0]  mCtl, mMode, nc, nm;
  logic [1:0]  mSync;
  logic        mPrev, mIrq, edgeHit, wc, wm;
  logic [15:0] mVec;
  logic [3:0]  pend;

  function automatic logic [15:0] vecOf(input logic [3:0] p);
    if (p[0]) return 16'hFFFA;
    if (p[1]) return 16'hFFF8;
    if (p[2]) return 16'hFFF6;
    if (p[3]) return 16'hFFF4;
    return 16'hFFFE;
  endfunction

  function automatic logic [7:0] readModel(input logic [7:0] a);
    if (a == 8'h0E) return mCtl;
    if (a == 8'h10) return mMode;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtl = 8'h01; mMode = 8'h00; mSync = 2'b00; mPrev = 1'b0;
      mIrq = 1'b0; mVec = 16'hFFFE;
    end else begin
      pend = {mMode[7] & mMode[0], mCtl[5] & mCtl[2], mCtl[4] & mCtl[1], mCtl[3] & mCtl[0]};
      mIrq = |pend;
      mVec = vecOf(pend);
      edgeHit = mCtl[6] ? (mSync[1] & !mPrev) : (!mSync[1] & mPrev);
      mPrev = mSync[1];
      mSync = {mSync[0], extPin};
      wc = wrEn && (busAddr == 8'h0E);
      wm = wrEn && (busAddr == 8'h10);
      nc = mCtl;
      if (wc) begin
        nc[6] = wrData[6];
        nc[2:0] = wrData[2:0];
        for (int b = 3; b <= 5; b++) if (!wrData[b]) nc[b] = 1'b0;
      end
      if (edgeHit) nc[3] = 1'b1;
      if (tmrAPulse) nc[4] = 1'b1;
      if (tmrBPulse) nc[5] = 1'b1;
      mCtl = nc;
      nm = mMode;
      if (wm) begin
        nm[0] = wrData[0];
        if (!wrData[7]) nm[7] = 1'b0;
      end
      if (serDonePulse) nm[7] = 1'b1;
      mMode = nm;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [7:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    chk(tag, {8'h00, d}, {8'h00, e});
  endtask

  task automatic expectOut(input string tag, input logic i, input logic [15:0] v);
    chk({tag, " irq"}, {15'h0, irqOut}, {15'h0, i});
    chk({tag, " vec"}, vecAddr, v);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: tmrAPulse = 1'b1;
      1: tmrBPulse = 1'b1;
      default: serDonePulse = 1'b1;
    endcase
    @(negedge clk);
    tmrAPulse = 1'b0; tmrBPulse = 1'b0; serDonePulse = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; extPin = 1'b1; tmrAPulse = 1'b0; tmrBPulse = 1'b0;
    serDonePulse = 1'b0; wrEn = 1'b0; busAddr = 8'h00; wrData = 8'h00;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    expectReg("R1 ctl reset", 8'h0E, 8'h01);
    expectReg("R1 mode reset", 8'h10, 8'h00);
    expectOut("R1 outputs", 1'b0, 16'hFFFE);

    // R2 Timer A latch, R5 blocked by mask
    pulse(0);
    expectReg("R2 timer A flag", 8'h0E, 8'h11);
    step(1);
    expectOut("R5 timer A masked", 1'b0, 16'hFFFE);
    // R4 write 1 keeps flag; R6 one-edge latency after unmasking
    wr(8'h0E, 8'h13);
    expectReg("R4 write one keeps", 8'h0E, 8'h13);
    expectOut("R6 not yet", 1'b0, 16'hFFFE);
    step(1);
    expectOut("R6 timer A request", 1'b1, 16'hFFF8);

    // R3 falling edge through synchronizer
    extPin = 1'b0;
    step(2);
    expectReg("R3 falling after two edges", 8'h0E, 8'h13);
    step(1);
    expectReg("R3 falling after three edges", 8'h0E, 8'h1B);
    step(1);
    expectOut("R7 external over timer A", 1'b1, 16'hFFFA);

    // R4 clear by writing 0
    wr(8'h0E, 8'h13);
    expectReg("R4 external cleared", 8'h0E, 8'h13);
    step(1);
    expectOut("R7 back to timer A", 1'b1, 16'hFFF8);

    // R3 rising polarity
    wr(8'h0E, 8'h53);
    extPin = 1'b1;
    step(2);
    expectReg("R3 rising after two edges", 8'h0E, 8'h53);
    step(1);
    expectReg("R3 rising after three edges", 8'h0E, 8'h5B);

    // clear all, then R4 event wins over clear
    wr(8'h0E, 8'h07);
    step(2);
    expectOut("R6 request drops", 1'b0, 16'hFFFE);
    pulse(1);
    expectReg("R2 timer B flag", 8'h0E, 8'h27);
    busAddr = 8'h0E; wrData = 8'h07; wrEn = 1'b1; tmrBPulse = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tmrBPulse = 1'b0;
    expectReg("R4 set beats clear", 8'h0E, 8'h27);
    step(1);
    expectOut("R7 timer B vector", 1'b1, 16'hFFF6);
    wr(8'h0E, 8'h07);
    expectReg("R4 timer B cleared", 8'h0E, 8'h07);
    step(2);

    // serial source
    pulse(2);
    expectReg("R2 serial flag", 8'h10, 8'h80);
    step(1);
    expectOut("R5 serial disabled", 1'b0, 16'hFFFE);
    wr(8'h10, 8'h81);
    expectReg("R5 serial enable", 8'h10, 8'h81);
    step(1);
    expectOut("R7 serial vector", 1'b1, 16'hFFF4);
    wr(8'h10, 8'h80);
    expectReg("R4 serial write one keeps", 8'h10, 8'h80);
    step(1);
    expectOut("R5 serial gated off", 1'b0, 16'hFFFE);
    wr(8'h10, 8'h00);
    expectReg("R4 serial cleared", 8'h10, 8'h00);

    // R8 reserved bits and foreign addresses
    wr(8'h20, 8'hFF);
    expectReg("R8 foreign write ctl", 8'h0E, 8'h07);
    expectReg("R8 foreign write mode", 8'h10, 8'h00);
    expectReg("R8 foreign read", 8'h20, 8'h00);
    wr(8'h0E, 8'hC7);
    expectReg("R8 ctl bit7 reads zero", 8'h0E, 8'h47);
    wr(8'h10, 8'h7F);
    expectReg("R8 mode reserved bits", 8'h10, 8'h01);

    // random phase against the cycle model
    void'($urandom(32'd12345));
    for (int c = 0; c < 3000; c++) begin
      expectOut("R6 R7 random", mIrq, mVec);
      tmrAPulse = ($urandom % 8) == 0;
      tmrBPulse = ($urandom % 8) == 0;
      serDonePulse = ($urandom % 8) == 0;
      if (($urandom % 10) == 0) extPin = ~extPin;
      case ($urandom % 3)
        0: busAddr = 8'h0E;
        1: busAddr = 8'h10;
        default: busAddr = 8'($urandom);
      endcase
      wrEn = ($urandom % 6) == 0;
      wrData = 8'($urandom);
      #1;
      chk("R2 R3 R4 R5 R8 random read", {8'h00, rdData}, {8'h00, readModel(busAddr)});
      @(negedge clk);
    end
    tmrAPulse = 1'b0; tmrBPulse = 1'b0; serDonePulse = 1'b0; wrEn = 1'b0;
    finishRun();
  end
endmodule